// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot

This block is the timekeeping core of a real-time clock. A one-cycle tick enable, pulsed once per second by an external divider, advances a calendar held entirely in BCD: seconds, minutes, hours (24-hour), day of week, date, month and a two-digit year. Month lengths are derived from the month and year. Every year from 00 to 99 that is divisible by four has a 29-day February.

Software never reaches the running counters directly. It sees a bank of holding registers through a small synchronous address/data port. Two control bits decide how that bank relates to the core. Raising the snapshot bit freezes a coherent copy of the time, and that copy already includes a tick arriving in the same cycle. Setting the lock bit lets software compose a new time in the bank. Clearing the lock bit copies the bank into the core in a single cycle. The core keeps counting in every mode.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the time reads 00:00:00, day of week 01, date 01, month 01, year 00, and the control register reads 00.
- R2: On a tick, seconds count 00 to 59 and wrap to 00 with a carry into minutes. Minutes do the same with a carry into hours. Hours wrap from 23 to 00 with a carry into the day.
- R3: Day of week advances on each day carry, cycling 01 through 07 and back to 01.
- R4: On a day carry, the date returns to 01 after the last day of the month (30 for months 04, 06, 09 and 11, 31 for the others except 02), with a carry into the month. The month wraps from 12 to 01 with a carry into the year. The year wraps from 99 to 00.
- R5: February has 29 days when the year (00..99) is divisible by four, and 28 days otherwise.
- R6: While both control bits are 0, the holding registers follow the core, so a read shows every tick. Read data is registered and appears one cycle after the address is applied.
- R7: Writing the snapshot bit from 0 to 1 captures the core time into the holding registers. A tick in that same cycle is included in the captured value.
- R8: While the snapshot bit is 1, the holding registers do not change and the core keeps counting. After the bit is cleared, reads show all ticks that passed.
- R9: While the lock bit is 1, writes to the time fields land in the holding registers and the registers do not follow the core. While the lock bit is 0, writes to the time fields have no effect.
- R10: Writing the lock bit from 1 to 0 loads the holding registers into the core. A tick in that same cycle is discarded.
- R11: Register map: address 0 is control, with bit 0 = snapshot and bit 1 = lock. Addresses 1 to 7 hold seconds, minutes, hours, day of week, date, month and year. Field writes keep only 7, 7, 6, 3, 6, 5 and 8 low bits respectively. Any other address reads 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse that advances time by one second |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |

## Verification
The hardest situations to reach are a tick landing in the same cycle as a control write. Two cases matter: the snapshot edge, where the tick must show up in the frozen copy, and the lock release, where the tick must be dropped. The bench drives the tick together with the control write in one cycle for both cases. It reaches distant calendar boundaries by loading a time one second before each boundary (end of a leap and a non-leap February, a 30-day month, the end of year 99) and then issuing a single tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int FIELD_W    = 8;

  // Field order puts seconds at index 0 and year at index NUM_FIELDS-1.
  typedef struct packed {
    logic [FIELD_W-1:0] year;
    logic [FIELD_W-1:0] month;
    logic [FIELD_W-1:0] date;
    logic [FIELD_W-1:0] dow;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] minute;
    logic [FIELD_W-1:0] second;
  } cal_time_t;

  typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_arr_t;

  localparam cal_time_t RESET_TIME = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                       dow: 8'h01, hour: 8'h00, minute: 8'h00,
                                       second: 8'h00};
  localparam field_arr_t RESET_ARR = field_arr_t'(RESET_TIME);

  // Bits kept on a write, per field index.
  function automatic logic [FIELD_W-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // Returns {wrap, next}. A value at or above hi wraps to lo.
  function automatic logic [FIELD_W:0] bcd_step(input logic [FIELD_W-1:0] val,
                                                 input logic [FIELD_W-1:0] lo,
                                                 input logic [FIELD_W-1:0] hi);
    if (val >= hi)           return {1'b1, lo};
    if (val[3:0] >= 4'd9)    return {1'b0, val[7:4] + 4'd1, 4'd0};
    return {1'b0, val[7:4], val[3:0] + 4'd1};
  endfunction

  function automatic logic leap_bcd(input logic [FIELD_W-1:0] yr);
    logic [6:0] bin;
    bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return bin[1:0] == 2'b00;
  endfunction

endpackage

// File: rtl/rtc_month_days.sv
module rtc_month_days
  import rtc_cal_pkg::*;
(
  input  logic [FIELD_W-1:0] month,
  input  logic [FIELD_W-1:0] year,
  output logic [FIELD_W-1:0] last_day
);

  always_comb begin
    case (month)
      8'h02:                      last_day = leap_bcd(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load_en,
  input  cal_time_t load_val,
  output cal_time_t cur_time,
  output cal_time_t next_time
);

  logic [FIELD_W-1:0] last_day;
  logic [FIELD_W:0]   st_sec, st_min, st_hour, st_dow, st_date, st_mon, st_year;
  logic               c_sec, c_min, c_hour, c_day, c_mon, c_year;

  rtc_month_days u_days (
    .month    (cur_time.month),
    .year     (cur_time.year),
    .last_day (last_day)
  );

  assign st_sec  = bcd_step(cur_time.second, 8'h00, 8'h59);
  assign st_min  = bcd_step(cur_time.minute, 8'h00, 8'h59);
  assign st_hour = bcd_step(cur_time.hour,   8'h00, 8'h23);
  assign st_dow  = bcd_step(cur_time.dow,    8'h01, 8'h07);
  assign st_date = bcd_step(cur_time.date,   8'h01, last_day);
  assign st_mon  = bcd_step(cur_time.month,  8'h01, 8'h12);
  assign st_year = bcd_step(cur_time.year,   8'h00, 8'h99);

  // Carry chain; a load in the same cycle suppresses the tick.
  assign c_sec  = tick && !load_en;
  assign c_min  = c_sec  && st_sec[FIELD_W];
  assign c_hour = c_min  && st_min[FIELD_W];
  assign c_day  = c_hour && st_hour[FIELD_W];
  assign c_mon  = c_day  && st_date[FIELD_W];
  assign c_year = c_mon  && st_mon[FIELD_W];

  always_comb begin
    if (load_en) begin
      next_time = load_val;
    end else begin
      next_time.second = c_sec  ? st_sec[FIELD_W-1:0]  : cur_time.second;
      next_time.minute = c_min  ? st_min[FIELD_W-1:0]  : cur_time.minute;
      next_time.hour   = c_hour ? st_hour[FIELD_W-1:0] : cur_time.hour;
      next_time.dow    = c_day  ? st_dow[FIELD_W-1:0]  : cur_time.dow;
      next_time.date   = c_day  ? st_date[FIELD_W-1:0] : cur_time.date;
      next_time.month  = c_mon  ? st_mon[FIELD_W-1:0]  : cur_time.month;
      next_time.year   = c_year ? st_year[FIELD_W-1:0] : cur_time.year;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_time <= RESET_TIME;
    else     cur_time <= next_time;
  end

endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [FIELD_W-1:0] reg_wdata,
  input  cal_time_t          core_next,
  output cal_time_t          hold_time,
  output logic               snap_r,
  output logic               lock_w,
  output logic               load_en,
  output logic [FIELD_W-1:0] reg_rdata
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  field_arr_t              core_arr;
  field_arr_t              hold_arr;
  logic [FIELD_W-1:0]      hold_q [NUM_FIELDS];
  logic [NUM_FIELDS-1:0]   field_we;
  logic                    ctrl_wr;
  logic                    tracking;
  logic [FIELD_W-1:0]      rd_next;

  assign core_arr = field_arr_t'(core_next);
  assign ctrl_wr  = reg_wr && (reg_addr == CTRL_ADDR);
  assign tracking = !snap_r && !lock_w;
  assign load_en  = ctrl_wr && lock_w && !reg_wdata[1];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_we
    assign field_we[i] = reg_wr && lock_w && (reg_addr == ADDR_W'(i + 1));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rst)              hold_q[i] <= RESET_ARR[i];
      else if (tracking)    hold_q[i] <= core_arr[i];
      else if (field_we[i]) hold_q[i] <= reg_wdata & field_mask(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_r <= 1'b0;
      lock_w <= 1'b0;
    end else if (ctrl_wr) begin
      snap_r <= reg_wdata[0];
      lock_w <= reg_wdata[1];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) hold_arr[i] = hold_q[i];
  end
  assign hold_time = cal_time_t'(hold_arr);

  always_comb begin
    rd_next = '0;
    if (reg_addr == CTRL_ADDR) rd_next = {6'b0, lock_w, snap_r};
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (reg_addr == ADDR_W'(i + 1)) rd_next = hold_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_1hz,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [FIELD_W-1:0] reg_wdata,
  output logic [FIELD_W-1:0] reg_rdata
);

  cal_time_t core_now;
  cal_time_t core_next;
  cal_time_t hold_time;
  logic      load_en;
  logic      ctrl_r;
  logic      ctrl_w;

  rtc_time_core u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_1hz),
    .load_en   (load_en),
    .load_val  (hold_time),
    .cur_time  (core_now),
    .next_time (core_next)
  );

  rtc_user_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .core_next (core_next),
    .hold_time (hold_time),
    .snap_r    (ctrl_r),
    .lock_w    (ctrl_w),
    .load_en   (load_en),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_1hz,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [FIELD_W-1:0] reg_wdata,
  input cal_time_t          core_now,
  input cal_time_t          hold_time,
  input logic               load_en,
  input logic               ctrl_r,
  input logic               ctrl_w
);

  // R1
  reset_time_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (core_now == RESET_TIME));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !load_en && core_now.second == 8'h59) |=> (core_now.second == 8'h00));

  // R3
  dow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !load_en && core_now.second == 8'h59 && core_now.minute == 8'h59 &&
     core_now.hour == 8'h23 && core_now.dow == 8'h07) |=> (core_now.dow == 8'h01));

  // R6
  track_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_r && !ctrl_w && !reg_wr) |=> (hold_time == core_now));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_r && !reg_wr) |=> $stable(hold_time));

  // R9
  lock_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w && reg_wr && reg_addr == ADDR_W'(1)) |=>
      (hold_time.second == ($past(reg_wdata) & 8'h7F)));

  // R10
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (core_now == $past(hold_time)));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_1hz  (tick_1hz),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .core_now  (core_now),
  .hold_time (hold_time),
  .load_en   (load_en),
  .ctrl_r    (ctrl_r),
  .ctrl_w    (ctrl_w)
);

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  started = 1'b0;
  bit  done = 1'b0;

  // Behavioural model: binary integers, index 0 = seconds .. 6 = year.
  int         m_core[7];
  int         m_hold[7];
  int         nc[7];
  bit         m_r, m_w, ld;
  logic [7:0] exp_rd = 8'h00;

  always #10 clk = ~clk;

  rtc_calendar_core #(.ADDR_W(4)) uut (
    .clk       (clk),
    .rst       (rst),
    .tick_1hz  (tick),
    .reg_wr    (wr),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] keep_bits(input int idx);
    case (idx)
      0, 1: return 8'h7F;
      2, 4: return 8'h3F;
      3:    return 8'h07;
      5:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic int month_len(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    started = 1'b1;
    if (rst) begin
      m_core = '{0, 0, 0, 1, 1, 1, 0};
      m_hold = '{0, 0, 0, 1, 1, 1, 0};
      m_r = 1'b0;
      m_w = 1'b0;
      exp_rd = 8'h00;
    end else begin
      if (addr == 0)                  exp_rd = {6'b0, m_w, m_r};
      else if (addr >= 1 && addr <= 7) exp_rd = to_bcd(m_hold[addr - 1]);
      else                            exp_rd = 8'h00;
      ld = wr && addr == 0 && m_w && !wdata[1];
      nc = m_core;
      if (ld) begin
        nc = m_hold;
      end else if (tick) begin
        nc[0] = nc[0] + 1;
        if (nc[0] == 60) begin
          nc[0] = 0; nc[1] = nc[1] + 1;
          if (nc[1] == 60) begin
            nc[1] = 0; nc[2] = nc[2] + 1;
            if (nc[2] == 24) begin
              nc[2] = 0;
              nc[3] = (nc[3] == 7) ? 1 : nc[3] + 1;
              nc[4] = nc[4] + 1;
              if (nc[4] > month_len(nc[5], nc[6])) begin
                nc[4] = 1; nc[5] = nc[5] + 1;
                if (nc[5] == 13) begin
                  nc[5] = 1;
                  nc[6] = (nc[6] == 99) ? 0 : nc[6] + 1;
                end
              end
            end
          end
        end
      end
      if (!m_r && !m_w)
        m_hold = nc;
      else if (wr && m_w && addr >= 1 && addr <= 7)
        m_hold[addr - 1] = from_bcd(wdata & keep_bits(addr - 1));
      m_core = nc;
      if (wr && addr == 0) begin
        m_r = wdata[0];
        m_w = wdata[1];
      end
    end
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // R6/R11 cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !rst) begin
      checks = checks + 1;
      if (rdata !== exp_rd) begin
        errors = errors + 1;
        $display("FAIL R6/R11 model compare: got %h expected %h", rdata, exp_rd);
      end
    end
  end

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    wr = 1'b0;
    addr = 4'(a);
    @(negedge clk);
    chk(rdata, exp, tag);
  endtask

  task automatic wreg(input int a, input logic [7:0] d, input bit t);
    @(negedge clk);
    wr = 1'b1;
    addr = 4'(a);
    wdata = d;
    tick = t;
    @(negedge clk);
    wr = 1'b0;
    tick = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                          input logic [7:0] dw, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
    wreg(0, 8'h02, 1'b0);
    wreg(1, s, 1'b0);
    wreg(2, mi, 1'b0);
    wreg(3, h, 1'b0);
    wreg(4, dw, 1'b0);
    wreg(5, dt, 1'b0);
    wreg(6, mo, 1'b0);
    wreg(7, yr, 1'b0);
    wreg(0, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(1, 8'h00, "R1 seconds");
    rd(2, 8'h00, "R1 minutes");
    rd(3, 8'h00, "R1 hours");
    rd(4, 8'h01, "R1 dow");
    rd(5, 8'h01, "R1 date");
    rd(6, 8'h01, "R1 month");
    rd(7, 8'h00, "R1 year");
    rd(0, 8'h00, "R1 control");

    // R2 R3 R5 rollover through a non-leap February end
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    pulse();
    rd(1, 8'h59, "R6 tracking shows tick");
    pulse();
    rd(1, 8'h00, "R2 seconds wrap");
    rd(2, 8'h00, "R2 minutes wrap");
    rd(3, 8'h00, "R2 hours wrap");
    rd(4, 8'h01, "R3 dow 7 to 1");
    rd(5, 8'h01, "R5 non-leap feb date");
    rd(6, 8'h03, "R5 non-leap feb month");

    // R5 leap year February
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    pulse();
    rd(5, 8'h29, "R5 leap feb 29");
    rd(6, 8'h02, "R5 leap stays feb");
    rd(4, 8'h04, "R3 dow step");
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    pulse();
    rd(5, 8'h01, "R5 leap feb end date");
    rd(6, 8'h03, "R5 leap feb end month");

    // R4 thirty-day month and year wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25);
    pulse();
    rd(5, 8'h01, "R4 april end date");
    rd(6, 8'h05, "R4 april end month");
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    pulse();
    rd(5, 8'h01, "R4 year end date");
    rd(6, 8'h01, "R4 year end month");
    rd(7, 8'h00, "R4 year 99 to 00");

    // R7 snapshot with a tick in the same cycle, R8 freeze
    set_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h15, 8'h06, 8'h30);
    wreg(0, 8'h01, 1'b1);
    pulse();
    pulse();
    pulse();
    rd(1, 8'h31, "R7 snapshot includes same-cycle tick");
    rd(0, 8'h01, "R11 control readback snapshot");
    wreg(0, 8'h00, 1'b0);
    rd(1, 8'h34, "R8 core ran while frozen");
    rd(2, 8'h20, "R8 minutes after release");

    // R9 lock and field writes, R11 masking
    wreg(0, 8'h02, 1'b0);
    pulse();
    pulse();
    rd(1, 8'h34, "R9 locked registers hold");
    wreg(1, 8'h45, 1'b0);
    rd(1, 8'h45, "R9 locked write accepted");
    wreg(3, 8'hE3, 1'b0);
    rd(3, 8'h23, "R11 hours keep six bits");
    wreg(3, 8'h10, 1'b0);
    rd(0, 8'h02, "R11 control readback lock");

    // R10 load with a discarded tick
    wreg(0, 8'h00, 1'b1);
    rd(1, 8'h45, "R10 load wins over tick");
    rd(3, 8'h10, "R10 hours loaded");
    pulse();
    rd(1, 8'h46, "R10 counting resumes");

    // R9 write while unlocked is ignored; R11 unmapped address
    wreg(1, 8'h11, 1'b0);
    rd(1, 8'h46, "R9 unlocked write ignored");
    rd(9, 8'h00, "R11 unmapped address");
    rd(0, 8'h00, "R11 control cleared");

    done = 1'b1;
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule